// File: doc/BRIEF.md
# Clock Crosspoint and Post-Divider Bank

This block takes four frequency sources, a reference and three PLL outputs, and distributes them to four general outputs through a crosspoint, each output with its own 7-bit post-divider. A fifth output always follows the first PLL through a small divider that only offers ratios of 2, 3 or 4, and a buffered copy of the reference is also provided. The whole block runs in one fast clock domain. Each source is presented as a single-cycle tick enable on that clock, and each output is a registered level that toggles at the divided rate.

Two of the general outputs each own a pair of divider registers. An external select input picks which register of the pair is used. Software writes the idle register and then flips the select, so the output never stops while it is being reprogrammed. A new divider value, or a new choice of register, is applied only when the current output period ends, so no runt pulse can appear. When one source drives several outputs, any output can be moved to an alternate phase that lags its siblings by one fast clock, so their transitions do not coincide.

Top module: `clkx_bank`

## Requirements
- R1: Output g (g = 0..3 for A..D) divides the source chosen by route_sel[2g+1:2g], with code 0 = reference (src_tick[0]), 1 = PLL1 (src_tick[1]), 2 = PLL2 (src_tick[2]) and 3 = PLL3 (src_tick[3]). Any source may feed any output, and a rising edge of a non-alternate output only follows a tick of its selected source.
- R2: For a divider value N of 2 or more, the output period is N ticks of the selected source. The output is high for floor(N/2) ticks and low for ceil(N/2) ticks. It changes on the clock edge that registers the tick that ends a phase. Values 2, 3 and 127 are all supported.
- R3: A divider value of 1 passes the tick rate through: the output is high for exactly the one clock cycle after each selected tick.
- R4: A divider value of 0 holds the output low.
- R5: The divider value for output A comes from div_main[6:0] when bank_sel[0]=0 and from div_alt[6:0] when bank_sel[0]=1. Output B uses div_main[13:7] or div_alt[13:7] under bank_sel[1] in the same way. Outputs C and D always use div_main[20:14] and div_main[27:21], and bank_sel has no effect on them.
- R6: A change of divider value or of bank_sel takes effect only at the end of the period in progress. That period completes with the old value, so every high phase lasts at least one source tick.
- R7: When phase_alt[g]=1, output g shows the same waveform delayed by one clock cycle.
- R8: clk_e divides PLL1 (src_tick[1]) with e_code 00 = divide by 2, 01 = divide by 3, and 10 or 11 = divide by 4. Its high and low phases follow R2.
- R9: ref_buf equals src_tick[0] in the same cycle, with no division.
- R10: While rst_n is low, all divided outputs are low. After reset, each divider starts its first period on the first tick of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Source tick enables: reference, PLL1, PLL2, PLL3 |
| route_sel | input | 8 | Crosspoint source code, 2 bits per output A..D |
| div_main | input | 28 | Primary divider value, 7 bits per output A..D |
| div_alt | input | 14 | Second divider register for outputs A and B |
| bank_sel | input | 2 | Register choice for outputs A and B |
| phase_alt | input | 4 | Per-output alternate-phase enable |
| e_code | input | 2 | Ratio code for output E |
| clk_out | output | 4 | Divided outputs A..D |
| clk_e | output | 1 | Divided PLL1 output |
| ref_buf | output | 1 | Buffered reference tick |

## Verification
The hardest case to reach is a bank switch that lands in the middle of an output period, because the switch has to arrive after the period has started but before it ends. The stimulus first waits for a rising edge of output A, then for the next tick of its source. Only then does it flip bank_sel. It counts the ticks left in the old period, then checks that the following period already uses the new value. The alternate-phase case needs two outputs that start in lockstep, so that test applies reset with both outputs already configured identically.

// File: rtl/clkx_pkg.sv
package clkx_pkg;

    localparam int E_DIV_W = 3;

    typedef enum logic [1:0] {
        E_BY2  = 2'b00,
        E_BY3  = 2'b01,
        E_BY4  = 2'b10,
        E_BY4X = 2'b11
    } e_ratio_e;

    function automatic logic [E_DIV_W-1:0] e_ratio(input logic [1:0] code);
        case (e_ratio_e'(code))
            E_BY2:   e_ratio = E_DIV_W'(2);
            E_BY3:   e_ratio = E_DIV_W'(3);
            default: e_ratio = E_DIV_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/clkx_xbar.sv
module clkx_xbar #(
    parameter int N_SRC = 4,
    parameter int N_OUT = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       src_tick,
    input  logic [N_OUT*SEL_W-1:0] route_sel,
    output logic [N_OUT-1:0]       out_tick
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_route
        assign out_tick[g] = src_tick[route_sel[g*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/clkx_div.sv
module clkx_div #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] req_div,
    input  logic         alt_phase,
    output logic         clk_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cur;
        logic         level;
        logic         late;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    period_end;

    always_comb begin
        st_d       = st_q;
        period_end = (st_q.cur <= W'(1)) || (st_q.cnt == st_q.cur - W'(1));
        if (tick) begin
            if (period_end) begin
                st_d.cnt = '0;
                st_d.cur = req_div;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
        if (st_d.cur == W'(1)) begin
            st_d.level = tick;
        end else begin
            st_d.level = (st_d.cur >= W'(2)) && (st_d.cnt < (st_d.cur >> 1));
        end
        st_d.late = st_q.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = alt_phase ? st_q.late : st_q.level;

endmodule

// File: rtl/clkx_bank.sv
module clkx_bank
    import clkx_pkg::*;
#(
    parameter int N_SRC    = 4,
    parameter int N_OUT    = 4,
    parameter int N_BANKED = 2,
    parameter int DIV_W    = 7,
    parameter int E_SRC    = 1,
    parameter int REF_SRC  = 0,
    localparam int SEL_W   = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       src_tick,
    input  logic [N_OUT*SEL_W-1:0] route_sel,
    input  logic [N_OUT*DIV_W-1:0] div_main,
    input  logic [N_BANKED*DIV_W-1:0] div_alt,
    input  logic [N_BANKED-1:0]    bank_sel,
    input  logic [N_OUT-1:0]       phase_alt,
    input  logic [1:0]             e_code,
    output logic [N_OUT-1:0]       clk_out,
    output logic                   clk_e,
    output logic                   ref_buf
);

    logic [N_OUT-1:0] routed_tick;

    clkx_xbar #(
        .N_SRC (N_SRC),
        .N_OUT (N_OUT)
    ) u_xbar (
        .src_tick  (src_tick),
        .route_sel (route_sel),
        .out_tick  (routed_tick)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic [DIV_W-1:0] req;
        if (g < N_BANKED) begin : g_banked
            assign req = bank_sel[g] ? div_alt[g*DIV_W +: DIV_W]
                                     : div_main[g*DIV_W +: DIV_W];
        end else begin : g_single
            assign req = div_main[g*DIV_W +: DIV_W];
        end

        clkx_div #(
            .W (DIV_W)
        ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (routed_tick[g]),
            .req_div   (req),
            .alt_phase (phase_alt[g]),
            .clk_o     (clk_out[g])
        );
    end

    clkx_div #(
        .W (E_DIV_W)
    ) u_div_e (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (src_tick[E_SRC]),
        .req_div   (e_ratio(e_code)),
        .alt_phase (1'b0),
        .clk_o     (clk_e)
    );

    assign ref_buf = src_tick[REF_SRC];

endmodule

// File: rtl/clkx_bank_chk.sv
module clkx_bank_chk #(
    parameter int N_SRC = 4,
    parameter int N_OUT = 4,
    parameter int E_SRC = 1,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_SRC-1:0]       src_tick,
    input logic [N_OUT*SEL_W-1:0] route_sel,
    input logic [N_OUT-1:0]       phase_alt,
    input logic [N_OUT-1:0]       clk_out,
    input logic                   clk_e
);

    logic [N_OUT-1:0] seen_q, seen_q2;
    logic             e_tick_q;
    logic [1:0]       e_hi_cnt;

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q[g]  <= 1'b0;
                seen_q2[g] <= 1'b0;
            end else begin
                seen_q[g]  <= src_tick[route_sel[g*SEL_W +: SEL_W]];
                seen_q2[g] <= seen_q[g];
            end
        end

        // R1: a plain-phase rising edge follows a tick of the chosen source
        p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(clk_out[g]) && !phase_alt[g] && !$past(phase_alt[g]))
            |-> seen_q[g]);

        // R7: an alternate-phase rising edge lags its tick by two cycles
        p_alt_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(clk_out[g]) && phase_alt[g] && $past(phase_alt[g])
             && $past(phase_alt[g], 2))
            |-> seen_q2[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_tick_q <= 1'b0;
            e_hi_cnt <= 2'd0;
        end else begin
            e_tick_q <= src_tick[E_SRC];
            if (!clk_e) begin
                e_hi_cnt <= 2'd0;
            end else if (src_tick[E_SRC] && e_hi_cnt != 2'd3) begin
                e_hi_cnt <= e_hi_cnt + 2'd1;
            end
        end
    end

    // R8: output E only rises after a PLL1 tick
    p_e_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_e) |-> e_tick_q);

    // R8: output E high phase never spans more than two PLL1 ticks
    p_e_high_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_e && src_tick[E_SRC]) |-> (e_hi_cnt <= 2'd1));

endmodule

bind clkx_bank clkx_bank_chk #(
    .N_SRC (N_SRC),
    .N_OUT (N_OUT),
    .E_SRC (E_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .route_sel (route_sel),
    .phase_alt (phase_alt),
    .clk_out   (clk_out),
    .clk_e     (clk_e)
);

// File: tb/clkx_bank_tb.sv
`timescale 1ns/1ps
module clkx_bank_tb;

    localparam real CYC = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic [7:0]  route_sel = '0;
    logic [27:0] div_main = '0;
    logic [13:0] div_alt = '0;
    logic [1:0]  bank_sel = '0;
    logic [3:0]  phase_alt = '0;
    logic [1:0]  e_code = '0;
    logic [3:0]  clk_out;
    logic        clk_e;
    logic        ref_buf;

    int checks = 0;
    int failures = 0;
    int per_cfg [4] = '{3, 4, 5, 7};
    int tcnt [4] = '{0, 1, 2, 3};

    clkx_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .route_sel (route_sel),
        .div_main  (div_main),
        .div_alt   (div_alt),
        .bank_sel  (bank_sel),
        .phase_alt (phase_alt),
        .e_code    (e_code),
        .clk_out   (clk_out),
        .clk_e     (clk_e),
        .ref_buf   (ref_buf)
    );

    always #(CYC/2) clk = ~clk;

    // periodic source ticks, driven just after each rising edge
    always @(posedge clk) begin
        #1;
        for (int s = 0; s < 4; s++) begin
            src_tick[s] = (tcnt[s] == 0);
            tcnt[s] = (tcnt[s] + 1) % per_cfg[s];
        end
    end

    initial begin
        #(CYC * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic obs(input int o);
        return (o < 4) ? clk_out[o] : clk_e;
    endfunction

    task automatic set_div(input int o, input int v);
        div_main[o*7 +: 7] = 7'(v);
    endtask

    task automatic set_route(input int o, input int s);
        route_sel[o*2 +: 2] = 2'(s);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rise(input int o);
        logic p;
        p = obs(o);
        forever begin
            @(negedge clk);
            if (obs(o) && !p) break;
            p = obs(o);
        end
    endtask

    // ticks of source s from one rising edge of output o to the next
    task automatic measure(input int o, input int s, output int per, output int hi);
        logic p;
        wait_rise(o);
        per = 0;
        hi = 0;
        forever begin
            if (src_tick[s]) begin
                per++;
                if (obs(o)) hi++;
            end
            p = obs(o);
            @(negedge clk);
            if (obs(o) && !p) break;
        end
    endtask

    task automatic t_reset();
        div_main = {7'd2, 7'd2, 7'd2, 7'd2};
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_out == 4'b0 && clk_e == 1'b0, "R10 outputs low in reset",
            int'({clk_e, clk_out}), 0);
        rst_n = 1'b1;
        chk(clk_out == 4'b0, "R10 outputs low right after reset", int'(clk_out), 0);
    endtask

    task automatic t_xbar();
        int per, hi;
        for (int rot = 0; rot < 4; rot++) begin
            bank_sel = 2'b00;
            phase_alt = '0;
            for (int g = 0; g < 4; g++) begin
                set_route(g, (g + rot) % 4);
                set_div(g, 3);
            end
            pulse_reset();
            for (int g = 0; g < 4; g++) begin
                measure(g, (g + rot) % 4, per, hi);
                chk(per == 3, $sformatf("R1 out%0d src%0d period", g, (g + rot) % 4), per, 3);
                chk(hi == 1, $sformatf("R2 out%0d odd high phase", g), hi, 1);
            end
        end
    endtask

    task automatic t_divs();
        int per, hi, bad;
        logic ptick;
        bank_sel = 2'b00;
        phase_alt = '0;
        set_route(0, 3); set_div(0, 2);
        set_route(1, 1); set_div(1, 0);
        set_route(2, 2); set_div(2, 127);
        set_route(3, 0); set_div(3, 1);
        pulse_reset();
        measure(0, 3, per, hi);
        chk(per == 2 && hi == 1, "R2 divide by 2", per * 10 + hi, 21);
        // R3 pass-through: high exactly the cycle after each tick
        bad = 0;
        ptick = src_tick[0];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_out[3] !== ptick) bad++;
            ptick = src_tick[0];
        end
        chk(bad == 0, "R3 divide by 1 follows ticks", bad, 0);
        // R4 zero holds low
        bad = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (clk_out[1] !== 1'b0) bad++;
        end
        chk(bad == 0, "R4 divide by 0 held low", bad, 0);
        measure(2, 2, per, hi);
        chk(per == 127, "R2 divide by 127 period", per, 127);
        chk(hi == 63, "R2 divide by 127 high phase", hi, 63);
    endtask

    task automatic t_bank();
        int per, hi, rem, rem_hi;
        phase_alt = '0;
        set_route(0, 1); set_div(0, 4); div_alt[6:0] = 7'd2;
        set_route(1, 2); set_div(1, 3); div_alt[13:7] = 7'd5;
        set_route(2, 0); set_div(2, 2);
        set_route(3, 3); set_div(3, 3);
        bank_sel = 2'b10;
        pulse_reset();
        measure(1, 2, per, hi);
        chk(per == 5, "R5 output B uses second register", per, 5);
        measure(0, 1, per, hi);
        chk(per == 4 && hi == 2, "R5 output A uses first register", per * 10 + hi, 42);
        bank_sel = 2'b11;
        measure(2, 0, per, hi);
        chk(per == 2, "R5 output C ignores bank select", per, 2);
        // switch A's bank one tick into a period
        bank_sel = 2'b10;
        wait_rise(0);
        while (!src_tick[1]) @(negedge clk);
        bank_sel = 2'b11;
        rem = 0;
        rem_hi = 0;
        forever begin
            logic p;
            p = obs(0);
            @(negedge clk);
            if (obs(0) && !p) break;
            if (src_tick[1]) begin
                rem++;
                if (obs(0)) rem_hi++;
            end
        end
        chk(rem == 3, "R6 old period completes after switch", rem, 3);
        chk(rem_hi == 1, "R6 old high phase kept", rem_hi, 1);
        measure(0, 1, per, hi);
        chk(per == 2 && hi >= 1, "R6 new value after boundary", per * 10 + hi, 21);
    endtask

    task automatic t_alt();
        int bad, edges;
        logic pa, pc;
        bank_sel = 2'b00;
        set_route(0, 2); set_div(0, 4);
        set_route(2, 2); set_div(2, 4);
        phase_alt = 4'b0100;
        pulse_reset();
        bad = 0;
        edges = 0;
        pa = clk_out[0];
        pc = clk_out[2];
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (clk_out[2] !== pa) bad++;
            if ((clk_out[0] != pa) && (clk_out[2] != pc)) bad++;
            if (clk_out[0] != pa) edges++;
            pa = clk_out[0];
            pc = clk_out[2];
        end
        chk(bad == 0, "R7 alternate phase lags by one cycle", bad, 0);
        chk(edges > 4, "R7 reference output toggles", edges, 5);
        phase_alt = '0;
    endtask

    task automatic t_e();
        int per, hi;
        int exp_per [4] = '{2, 3, 4, 4};
        int exp_hi [4] = '{1, 1, 2, 2};
        for (int c = 0; c < 4; c++) begin
            e_code = 2'(c);
            pulse_reset();
            measure(4, 1, per, hi);
            chk(per == exp_per[c], $sformatf("R8 code %0d period", c), per, exp_per[c]);
            chk(hi == exp_hi[c], $sformatf("R8 code %0d high phase", c), hi, exp_hi[c]);
        end
    endtask

    task automatic t_ref();
        int bad;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (ref_buf !== src_tick[0]) bad++;
        end
        chk(bad == 0, "R9 buffered reference follows source", bad, 0);
    endtask

    initial begin
        t_reset();
        t_xbar();
        t_divs();
        t_bank();
        t_alt();
        t_e();
        t_ref();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule